// File: doc/BRIEF.md
# Snooping Coherence State Controller for Four Private Caches

This block keeps the coherence bookkeeping for a set of private write-back data caches that sit in front of one shared memory. Every core can ask to read a tracked line, write it, or clean-and-invalidate it. The controller accepts one of these requests per cycle. It looks at the copies held by the other cores and updates the state of that line in every core at once. It reports whether the requester's data comes from its own copy, from a peer cache or from memory. It raises a one-cycle write-back pulse with the line index whenever dirty data has to reach memory.

Each line copy is stored as three bits: valid, dirty and unique. Modified, Owned, Exclusive, Shared and Invalid are combinations of these bits. A configuration bit turns snooping on. While that bit is clear, each core's lines change only on that core's own requests, as in a stand-alone write-back cache. The data arrays, replacement and the physical bus are outside this block.

Top module: `coh_snoop_ctrl`

## Requirements
- R1: Each core's copy of each line is exposed on `stateFlat` as three bits {valid, dirty, unique} at bit offset ((core*NUM_LINES)+line)*3. Modified=111, Owned=110, Exclusive=101, Shared=100, Invalid=000.
- R2: After reset every copy in every core is Invalid (000), and `respValid` and `wbValid` are 0.
- R3: A read (op 0) by a core without a copy, when no other core holds the line, makes the requester Exclusive with source memory (`respSrc`=1).
- R4: A write (op 1) leaves the writer Modified and, with snooping on, every other copy Invalid. No write-back is raised. The source is the writer's own copy (`respSrc`=3) if it was valid, otherwise a peer (2) if any other copy exists, otherwise memory (1).
- R5: A read miss while another core holds the line dirty turns that holder Owned and the reader Shared. The source is peer (`respSrc`=2) with `respPeer` equal to the dirty holder.
- R6: A read miss while other copies are all clean makes the reader Shared, turns any Exclusive copy Shared, and names the lowest-numbered holder as `respPeer`.
- R7: A clean-and-invalidate (op 2) makes the requester Invalid and leaves every other copy unchanged. It raises `wbValid` with `wbLine` equal to the line exactly when the requester's copy was dirty. `respSrc` is 0.
- R8: The snooping enable resets to 0 and is loaded from `cfgCohEn` when `cfgWr` is 1. While it is 0, a read miss always fills Exclusive from memory and a write leaves other cores' copies untouched.
- R9: At most one request is served per cycle. Among asserted `reqValid` bits the grant goes round-robin, starting from core 0 after reset and then from the core after the last one granted.
- R10: With snooping on, no line ever has more than one dirty copy, and a unique copy is never held together with another valid copy.
- R11: A read by a core already holding a valid copy reports `respSrc`=3 and changes no state.
- R12: The response (`respValid`, `respCore`, `respLine`, `respSrc`, `respPeer`) and the write-back pulse appear in the cycle after acceptance, together with the new states. With no request, `respValid` and `wbValid` are 0. Op 3 is served as a no-operation: `respSrc`=0 and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWr | input | 1 | Load strobe for the snooping enable |
| cfgCohEn | input | 1 | Value loaded into the snooping enable |
| reqValid | input | NUM_CORES | Per-core request present |
| reqOp | input | 2*NUM_CORES | Per-core opcode (0 read, 1 write, 2 clean-and-invalidate, 3 no-op), core c at bits 2c+1:2c |
| reqLine | input | LINE_W*NUM_CORES | Per-core tracked line index |
| respValid | output | 1 | A request was served last cycle |
| respCore | output | IDX_W | Core that was served |
| respLine | output | LINE_W | Line that was served |
| respSrc | output | 2 | Data source: 0 none, 1 memory, 2 peer, 3 own copy |
| respPeer | output | IDX_W | Supplying core when source is peer, else 0 |
| wbValid | output | 1 | One-cycle write-back pulse |
| wbLine | output | LINE_W | Line being written back |
| stateFlat | output | 3*NUM_CORES*NUM_LINES | All per-core line states |

## Verification
The main sequence drives one line through a chain of requests from all four cores. The chain passes through every state pair that matters: fill from memory, silent upgrade, dirty sharing, taking ownership from Shared and from Modified, and clean-and-invalidate on both an Owned copy and a Shared copy. Each step checks the full four-core state and the reported source. This separates a peer supply from a dirty owner, a peer supply from a clean holder, a memory fill and a hit. A second line checks that a clean Exclusive holder is demoted on a peer read. A run with snooping left at its reset value shows that copies stay independent. Four requests held together show the round-robin order.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef struct packed {
    logic vld;
    logic drt;
    logic uniq;
  } lstate_t;

  localparam lstate_t ST_INV = '{vld: 1'b0, drt: 1'b0, uniq: 1'b0};
  localparam lstate_t ST_SHR = '{vld: 1'b1, drt: 1'b0, uniq: 1'b0};
  localparam lstate_t ST_EXC = '{vld: 1'b1, drt: 1'b0, uniq: 1'b1};
  localparam lstate_t ST_MOD = '{vld: 1'b1, drt: 1'b1, uniq: 1'b1};

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_CLNINV = 2'd2,
    OP_NOP   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_MEM  = 2'd1,
    SRC_PEER = 2'd2,
    SRC_HIT  = 2'd3
  } src_e;

  typedef struct packed {
    logic go;
    logic cohOn;
    op_e  op;
  } ctrl_strobe_t;

endpackage

// File: rtl/coh_rr_arbiter.sv
module coh_rr_arbiter #(
  parameter int N = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  output logic             gntAny,
  output logic [IDX_W-1:0] gntIdx
);

  logic [IDX_W-1:0] rrPtr;

  always_comb begin
    int cand;
    gntAny = 1'b0;
    gntIdx = '0;
    cand = 0;
    for (int k = 0; k < N; k++) begin
      cand = (int'(rrPtr) + k) % N;
      if (!gntAny && req[cand]) begin
        gntAny = 1'b1;
        gntIdx = IDX_W'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rrPtr <= '0;
    end else if (gntAny) begin
      rrPtr <= (int'(gntIdx) == N - 1) ? '0 : gntIdx + 1'b1;
    end
  end

  // R9: a core held in contention is not served twice in a row
  p_rotate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gntAny && (&req) && $past(gntAny && (&req))) |-> (gntIdx != $past(gntIdx)));

  // R9: the grant only ever lands on a requesting core
  p_grant_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    gntAny |-> req[gntIdx]);

endmodule

// File: rtl/coh_ctrl.sv
module coh_ctrl
  import coh_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int LINE_W = 2,
  parameter int IDX_W = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfgWr,
  input  logic                        cfgCohEn,
  input  logic [NUM_CORES-1:0]        reqValid,
  input  logic [2*NUM_CORES-1:0]      reqOp,
  input  logic [LINE_W*NUM_CORES-1:0] reqLine,
  output ctrl_strobe_t                strobe,
  output logic [IDX_W-1:0]            selCore,
  output logic [LINE_W-1:0]           selLine
);

  logic             cohEnQ;
  logic             gntAny;
  logic [IDX_W-1:0] gntIdx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cohEnQ <= 1'b0;
    end else if (cfgWr) begin
      cohEnQ <= cfgCohEn;
    end
  end

  coh_rr_arbiter #(
    .N(NUM_CORES),
    .IDX_W(IDX_W)
  ) u_arb (
    .clk(clk),
    .rst_n(rst_n),
    .req(reqValid),
    .gntAny(gntAny),
    .gntIdx(gntIdx)
  );

  always_comb begin
    strobe.go    = gntAny;
    strobe.cohOn = cohEnQ;
    strobe.op    = op_e'(reqOp[int'(gntIdx)*2 +: 2]);
    selCore      = gntIdx;
    selLine      = reqLine[int'(gntIdx)*LINE_W +: LINE_W];
  end

  // R8: the enable only moves on a configuration write
  p_en_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfgWr) |-> $stable(cohEnQ));

endmodule

// File: rtl/coh_state_dp.sv
module coh_state_dp
  import coh_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_LINES = 4,
  parameter int LINE_W = 2,
  parameter int IDX_W = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  ctrl_strobe_t                      strobe,
  input  logic [IDX_W-1:0]                  selCore,
  input  logic [LINE_W-1:0]                 selLine,
  output logic                              respValid,
  output logic [IDX_W-1:0]                  respCore,
  output logic [LINE_W-1:0]                 respLine,
  output logic [1:0]                        respSrc,
  output logic [IDX_W-1:0]                  respPeer,
  output logic                              wbValid,
  output logic [LINE_W-1:0]                 wbLine,
  output logic [3*NUM_CORES*NUM_LINES-1:0]  stateFlat
);

  lstate_t st  [NUM_CORES][NUM_LINES];
  lstate_t cur [NUM_CORES];
  lstate_t nxt [NUM_CORES];

  src_e             srcN;
  logic [IDX_W-1:0] peerN;
  logic             wbN;
  src_e             srcQ;

  always_comb begin
    for (int c = 0; c < NUM_CORES; c++) begin
      cur[c] = st[c][selLine];
    end
  end

  // Snoop the other copies and derive every core's next state for the line
  always_comb begin
    lstate_t          me;
    logic             otherValid;
    logic             otherDirty;
    logic [IDX_W-1:0] dirtyIdx;
    logic [IDX_W-1:0] validIdx;
    me         = cur[selCore];
    otherValid = 1'b0;
    otherDirty = 1'b0;
    dirtyIdx   = '0;
    validIdx   = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      nxt[c] = cur[c];
    end
    for (int c = NUM_CORES - 1; c >= 0; c--) begin
      if (c != int'(selCore) && cur[c].vld) begin
        otherValid = 1'b1;
        validIdx   = IDX_W'(c);
        if (cur[c].drt) begin
          otherDirty = 1'b1;
          dirtyIdx   = IDX_W'(c);
        end
      end
    end
    srcN  = SRC_NONE;
    peerN = '0;
    wbN   = 1'b0;
    case (strobe.op)
      OP_READ: begin
        if (me.vld) begin
          srcN = SRC_HIT;
        end else if (strobe.cohOn && otherValid) begin
          srcN  = SRC_PEER;
          peerN = otherDirty ? dirtyIdx : validIdx;
          nxt[selCore] = ST_SHR;
          for (int c = 0; c < NUM_CORES; c++) begin
            if (c != int'(selCore)) begin
              nxt[c].uniq = 1'b0;
            end
          end
        end else begin
          srcN = SRC_MEM;
          nxt[selCore] = ST_EXC;
        end
      end
      OP_WRITE: begin
        if (me.vld) begin
          srcN = SRC_HIT;
        end else if (strobe.cohOn && otherValid) begin
          srcN  = SRC_PEER;
          peerN = otherDirty ? dirtyIdx : validIdx;
        end else begin
          srcN = SRC_MEM;
        end
        if (strobe.cohOn) begin
          for (int c = 0; c < NUM_CORES; c++) begin
            nxt[c] = ST_INV;
          end
        end
        nxt[selCore] = ST_MOD;
      end
      OP_CLNINV: begin
        wbN = me.drt;
        nxt[selCore] = ST_INV;
      end
      default: begin
        srcN = SRC_NONE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CORES; c++) begin
        for (int l = 0; l < NUM_LINES; l++) begin
          st[c][l] <= ST_INV;
        end
      end
    end else if (strobe.go) begin
      for (int c = 0; c < NUM_CORES; c++) begin
        st[c][selLine] <= nxt[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      respValid <= 1'b0;
      respCore  <= '0;
      respLine  <= '0;
      srcQ      <= SRC_NONE;
      respPeer  <= '0;
      wbValid   <= 1'b0;
      wbLine    <= '0;
    end else begin
      respValid <= strobe.go;
      wbValid   <= strobe.go && wbN;
      if (strobe.go) begin
        respCore <= selCore;
        respLine <= selLine;
        srcQ     <= srcN;
        respPeer <= peerN;
        wbLine   <= selLine;
      end
    end
  end

  assign respSrc = srcQ;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_flat_core
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_flat_line
      assign stateFlat[(c*NUM_LINES+l)*3 +: 3] = st[c][l];
    end
  end

  // Invariants are only promised while no request was served with snooping off
  logic invOk;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      invOk <= 1'b1;
    end else if (strobe.go && !strobe.cohOn) begin
      invOk <= 1'b0;
    end
  end

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_inv
    logic [NUM_CORES-1:0] dv;
    logic [NUM_CORES-1:0] vv;
    logic [NUM_CORES-1:0] uv;
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_bits
      assign dv[c] = st[c][l].drt;
      assign vv[c] = st[c][l].vld;
      assign uv[c] = st[c][l].uniq;
    end
    // R10: a single dirty copy per line
    p_one_dirty_r10: assert property (@(posedge clk) disable iff (!rst_n || !invOk)
      $countones(dv) <= 1);
    // R10: a unique copy stands alone
    p_unique_alone_r10: assert property (@(posedge clk) disable iff (!rst_n || !invOk)
      (|uv) |-> ($countones(vv) == 1));
  end

  // R7: the core whose dirty line is being written back no longer holds it
  p_wb_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wbValid |-> !st[respCore][wbLine].vld);

  // R5: a peer supply never names the requester itself
  p_peer_other_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (respValid && srcQ == SRC_PEER) |-> (respPeer != respCore));

  // R12: write-back pulses only accompany a served request
  p_wb_with_resp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wbValid |-> respValid);

endmodule

// File: rtl/coh_snoop_ctrl.sv
module coh_snoop_ctrl
  import coh_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_LINES = 4,
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfgWr,
  input  logic                             cfgCohEn,
  input  logic [NUM_CORES-1:0]             reqValid,
  input  logic [2*NUM_CORES-1:0]           reqOp,
  input  logic [LINE_W*NUM_CORES-1:0]      reqLine,
  output logic                             respValid,
  output logic [IDX_W-1:0]                 respCore,
  output logic [LINE_W-1:0]                respLine,
  output logic [1:0]                       respSrc,
  output logic [IDX_W-1:0]                 respPeer,
  output logic                             wbValid,
  output logic [LINE_W-1:0]                wbLine,
  output logic [3*NUM_CORES*NUM_LINES-1:0] stateFlat
);

  ctrl_strobe_t      strobe;
  logic [IDX_W-1:0]  selCore;
  logic [LINE_W-1:0] selLine;

  coh_ctrl #(
    .NUM_CORES(NUM_CORES),
    .LINE_W(LINE_W),
    .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk),
    .rst_n(rst_n),
    .cfgWr(cfgWr),
    .cfgCohEn(cfgCohEn),
    .reqValid(reqValid),
    .reqOp(reqOp),
    .reqLine(reqLine),
    .strobe(strobe),
    .selCore(selCore),
    .selLine(selLine)
  );

  coh_state_dp #(
    .NUM_CORES(NUM_CORES),
    .NUM_LINES(NUM_LINES),
    .LINE_W(LINE_W),
    .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk),
    .rst_n(rst_n),
    .strobe(strobe),
    .selCore(selCore),
    .selLine(selLine),
    .respValid(respValid),
    .respCore(respCore),
    .respLine(respLine),
    .respSrc(respSrc),
    .respPeer(respPeer),
    .wbValid(wbValid),
    .wbLine(wbLine),
    .stateFlat(stateFlat)
  );

endmodule

// File: tb/coh_snoop_ctrl_tb.sv
`timescale 1ns/1ps
module coh_snoop_ctrl_tb;

  localparam logic [1:0] RD = 2'd0, WR = 2'd1, CI = 2'd2, NP = 2'd3;
  localparam logic [1:0] SN = 2'd0, SM = 2'd1, SP = 2'd2, SH = 2'd3;
  localparam logic [2:0] M_ = 3'b111, O_ = 3'b110, E_ = 3'b101, S_ = 3'b100, I_ = 3'b000;

  typedef struct packed {
    logic [1:0]  core;
    logic [1:0]  op;
    logic [1:0]  line;
    logic [1:0]  src;
    logic [1:0]  peer;
    logic        wb;
    logic [11:0] sts;   // {core3, core2, core1, core0}
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{2'd0, RD, 2'd1, SM, 2'd0, 1'b0, {I_, I_, I_, E_}},
    '{2'd0, WR, 2'd1, SH, 2'd0, 1'b0, {I_, I_, I_, M_}},
    '{2'd1, RD, 2'd1, SP, 2'd0, 1'b0, {I_, I_, S_, O_}},
    '{2'd2, RD, 2'd1, SP, 2'd0, 1'b0, {I_, S_, S_, O_}},
    '{2'd3, RD, 2'd1, SP, 2'd0, 1'b0, {S_, S_, S_, O_}},
    '{2'd1, CI, 2'd1, SN, 2'd0, 1'b0, {S_, S_, I_, O_}},
    '{2'd0, CI, 2'd1, SN, 2'd0, 1'b1, {S_, S_, I_, I_}},
    '{2'd2, WR, 2'd1, SH, 2'd0, 1'b0, {I_, M_, I_, I_}},
    '{2'd3, WR, 2'd1, SP, 2'd2, 1'b0, {M_, I_, I_, I_}},
    '{2'd1, RD, 2'd1, SP, 2'd3, 1'b0, {O_, I_, S_, I_}},
    '{2'd1, WR, 2'd1, SH, 2'd0, 1'b0, {I_, I_, M_, I_}},
    '{2'd0, RD, 2'd1, SP, 2'd1, 1'b0, {I_, I_, O_, S_}},
    '{2'd0, RD, 2'd1, SH, 2'd0, 1'b0, {I_, I_, O_, S_}},
    '{2'd1, CI, 2'd1, SN, 2'd0, 1'b1, {I_, I_, I_, S_}},
    '{2'd2, RD, 2'd1, SP, 2'd0, 1'b0, {I_, S_, I_, S_}},
    '{2'd3, RD, 2'd2, SM, 2'd0, 1'b0, {E_, I_, I_, I_}},
    '{2'd0, RD, 2'd2, SP, 2'd3, 1'b0, {S_, I_, I_, S_}},
    '{2'd0, RD, 2'd0, SM, 2'd0, 1'b0, {I_, I_, I_, E_}},
    '{2'd0, WR, 2'd0, SH, 2'd0, 1'b0, {I_, I_, I_, M_}},
    '{2'd0, CI, 2'd0, SN, 2'd0, 1'b1, {I_, I_, I_, I_}},
    '{2'd2, NP, 2'd2, SN, 2'd0, 1'b0, {S_, I_, I_, S_}}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWr = 1'b0;
  logic        cfgCohEn = 1'b0;
  logic [3:0]  reqValid = '0;
  logic [7:0]  reqOp = '0;
  logic [7:0]  reqLine = '0;
  logic        respValid;
  logic [1:0]  respCore;
  logic [1:0]  respLine;
  logic [1:0]  respSrc;
  logic [1:0]  respPeer;
  logic        wbValid;
  logic [1:0]  wbLine;
  logic [47:0] stateFlat;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  coh_snoop_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfgWr(cfgWr), .cfgCohEn(cfgCohEn),
    .reqValid(reqValid), .reqOp(reqOp), .reqLine(reqLine),
    .respValid(respValid), .respCore(respCore), .respLine(respLine),
    .respSrc(respSrc), .respPeer(respPeer), .wbValid(wbValid),
    .wbLine(wbLine), .stateFlat(stateFlat)
  );

  function automatic logic [2:0] stOf(int c, int l);
    return stateFlat[(c*4+l)*3 +: 3];
  endfunction

  function automatic logic [11:0] lineSts(int l);
    return {stOf(3, l), stOf(2, l), stOf(1, l), stOf(0, l)};
  endfunction

  task automatic chk(string tag, string what, logic [47:0] act, logic [47:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic doReset();
    rst_n = 1'b0;
    reqValid = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic setEnable(logic en);
    cfgWr = 1'b1;
    cfgCohEn = en;
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  // drive on a falling edge, accepted at the next rising edge, sampled one falling edge later
  task automatic issue(int core, logic [1:0] op, int line);
    reqValid = '0;
    reqValid[core] = 1'b1;
    reqOp[core*2 +: 2] = op;
    reqLine[core*2 +: 2] = 2'(line);
    @(negedge clk);
    reqValid = '0;
  endtask

  function automatic string tagFor(logic [1:0] op, logic [1:0] src);
    if (op == WR) return "R4";
    if (op == CI) return "R7";
    if (op == NP) return "R12";
    if (src == SM) return "R3";
    if (src == SH) return "R11";
    return "R5/R6";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    doReset();
    // R2: reset state
    chk("R2", "states after reset", stateFlat, 48'd0);
    chk("R2", "respValid after reset", respValid, 0);
    chk("R2", "wbValid after reset", wbValid, 0);

    // R8: snooping left disabled after reset, cores behave independently
    issue(0, RD, 0);
    chk("R8", "core0 fill source", respSrc, SM);
    issue(1, RD, 0);
    chk("R8", "core1 fill source", respSrc, SM);
    chk("R8", "line0 both exclusive", lineSts(0), {I_, I_, E_, E_});
    issue(0, WR, 0);
    chk("R8", "line0 after independent write", lineSts(0), {I_, I_, E_, M_});

    doReset();
    chk("R2", "reset clears dirty copies", stateFlat, 48'd0);
    setEnable(1'b1);

    // R9: four simultaneous requests served in rotation
    reqValid = 4'hF;
    reqOp = 8'h00;
    reqLine = 8'hFF;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R9", "round-robin grant", respCore, 48'(i));
      chk("R9", "one response per cycle", respValid, 1);
    end
    reqValid = '0;
    chk("R6", "line3 after four reads", lineSts(3), {S_, S_, S_, S_});
    @(negedge clk);
    chk("R12", "idle respValid", respValid, 0);
    chk("R12", "idle wbValid", wbValid, 0);

    // R1 R3 R4 R5 R6 R7 R11: transition table
    for (int v = 0; v < NV; v++) begin
      string t;
      t = tagFor(VEC[v].op, VEC[v].src);
      issue(int'(VEC[v].core), VEC[v].op, int'(VEC[v].line));
      chk(t, $sformatf("row %0d respValid", v), respValid, 1);
      chk(t, $sformatf("row %0d respCore", v), respCore, VEC[v].core);
      chk(t, $sformatf("row %0d respLine", v), respLine, VEC[v].line);
      chk(t, $sformatf("row %0d respSrc", v), respSrc, VEC[v].src);
      if (VEC[v].src == SP)
        chk(t, $sformatf("row %0d respPeer", v), respPeer, VEC[v].peer);
      chk(t, $sformatf("row %0d wbValid", v), wbValid, VEC[v].wb);
      if (VEC[v].wb)
        chk(t, $sformatf("row %0d wbLine", v), wbLine, VEC[v].line);
      chk("R1", $sformatf("row %0d line states", v), lineSts(int'(VEC[v].line)), VEC[v].sts);
    end
    @(negedge clk);
    chk("R12", "write-back is a single pulse", wbValid, 0);
    chk("R7", "line3 untouched by other lines", lineSts(3), {S_, S_, S_, S_});
    chk("R10", "line1 single dirty or none", lineSts(1), {I_, S_, I_, S_});

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule